// File: doc/BRIEF.md
# Quad-Port Global Control Register

This block sits between a host bus and four identical port register banks. Host writes and reads carry an address, write data and a strobe. Most of the address space belongs to the banks. The block picks the target bank from the top address bits and passes the lower bits through as an offset. One address, 0x0F0, is reserved for the block's own 8-bit global control register, and that address takes priority over the bank decode. Every bit of the register resets to 0.

The register fields act as follows:

- **Broadcast (bit 2).** While set, any bank write is fanned out to all four banks in the same cycle. This lets software initialise the device quickly. Port reads are refused while broadcast is on, and the refusal is flagged.
- **Counter latch (bit 1).** A 0-to-1 change of this field produces a one-cycle latch pulse. The pulse reaches every port whose latch-enable input is high. Software must clear the field and set it again to produce another pulse.
- **Interrupt inhibit (bit 0).** Controls the active-low interrupt output.
- **Status select (bit 5).** Chooses which per-port condition appears on the per-port status pins.
- **Bus-combining mode (bit 4).** Drives a mode output that selects how the serial lines are combined.

Top module: `qport_global_ctrl`

## Requirements
- R1: After reset the global register reads 0x00, `irq_n` is 1, `port_latch` is 0, `bulk_rd_err` is 0 and `wire_or_mode` is 0. While reset is held, `irq_n` stays 1 even with port interrupts pending.
- R2: A host access to address 0x0F0 reaches the global register. A read returns the stored value on `host_rdata` in the same cycle. Bits 7, 6 and 3 always read 0, and writes to them are ignored. Bits 5, 4, 2, 1 and 0 read back the last value written to them.
- R3: Any other address targets bank `host_addr[9:8]` at offset `host_addr[7:0]`, and that offset appears on `port_addr`. With broadcast (bit 2) clear, a write raises only that bank's bit of `port_wr`, in the same cycle as `host_wr`. A write to 0x0F0 raises no `port_wr` bit.
- R4: With broadcast (bit 2) set, a bank write raises all four `port_wr` bits in the same cycle, with the same offset and data. The new value of bit 2 governs writes that follow the register write.
- R5: With broadcast clear, a bank read raises only that bank's bit of `port_rd`. In the same cycle, `host_rdata` returns that bank's slice of `port_rdata`, where bank i occupies bits [8i+7:8i].
- R6: With broadcast set, a bank read raises no `port_rd` bit and returns 0 on `host_rdata`. It also drives `bulk_rd_err` high for exactly the one cycle after the read. A read of 0x0F0 never raises `bulk_rd_err`.
- R7: A register write that changes bit 1 from 0 to 1 drives `port_latch[i]` high for one cycle, in the cycle after the write's clock edge, for each port i whose `port_latch_en[i]` is 1. Ports with `port_latch_en[i]` at 0 get no pulse.
- R8: Writing 1 to bit 1 while it already holds 1 produces no pulse, and neither does a write that changes only other bits. Writing 0 and then 1 again produces a new pulse.
- R9: With bit 0 at 0, `irq_n` is 0 one cycle after any `port_irq` bit is high, and 1 one cycle after all are low. With bit 0 at 1, `irq_n` is 1.
- R10: `port_stat[i]` shows `port_rlof[i]` when bit 5 is 0 and `port_ltc[i]` when bit 5 is 1. The pin follows its input combinationally.
- R11: `wire_or_mode` equals bit 4 of the global register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 10 | Host address: bank in [9:8], offset in [7:0] |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read data, valid in the cycle of `host_rd` |
| bulk_rd_err | output | 1 | One-cycle flag for a bank read refused under broadcast |
| port_addr | output | 8 | Offset inside the selected bank |
| port_wdata | output | 8 | Write data to the banks |
| port_wr | output | 4 | Per-bank write strobes |
| port_rd | output | 4 | Per-bank read strobes |
| port_rdata | input | 32 | Read data from the banks, 8 bits per bank |
| port_latch_en | input | 4 | Per-port acceptance of the counter latch event |
| port_latch | output | 4 | Per-port counter latch pulse |
| port_irq | input | 4 | Per-port pending unmasked interrupt |
| irq_n | output | 1 | Active-low combined interrupt |
| port_rlof | input | 4 | Per-port receive loss-of-frame condition |
| port_ltc | input | 4 | Per-port loss-of-transmit-clock condition |
| port_stat | output | 4 | Per-port status pin |
| wire_or_mode | output | 1 | Serial-line combining mode select |

## Verification
The bench writes every bank offset and reads it back. A decoder that aliased banks, or that leaked a strobe into a neighbouring bank, would leave a mismatch somewhere in the full comparison of the four bank models. Broadcast is tested on both writes and reads. A design that read a bank under broadcast, or that forgot to raise the error for exactly one cycle, would return stale data or a missing or stretched flag.

Every latch-enable pattern is driven through set, rewrite-while-set, change-other-bits and clear-then-set sequences. A level-sensitive latch would pulse on the rewrite, and a stretched pulse would still be high a cycle later. All 256 register values are written to catch reserved bits that store data. The status select is swept over every input pattern, and so is the interrupt gate under both inhibit settings.

// File: rtl/qgc_pkg.sv
// Package: shared field layout of the global control register.
// Assumes an 8-bit register; field positions are fixed by the host's software.
package qgc_pkg;

    localparam int CTRL_W = 8;

    // Bits that store a value; every other bit reads back 0.
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'h37;

    typedef struct packed {
        logic [1:0] rsv_hi;    // bits 7:6, reserved
        logic       stat_sel;  // bit 5: status pin source
        logic       wor_mode;  // bit 4: serial combining mode
        logic       rsv_mid;   // bit 3, reserved
        logic       bulk;      // bit 2: broadcast writes
        logic       latch;     // bit 1: counter latch trigger
        logic       inhibit;   // bit 0: interrupt inhibit
    } ctrl_t;

endpackage

// File: rtl/qgc_addr_decode.sv
// Address decode and strobe fan-out for the host bus.
// Separates the global register address from bank addresses, and builds
// per-bank write and read strobes.
// Assumes NPORTS is a power of two; the bank index is the top address bits.
module qgc_addr_decode #(
    parameter int                NPORTS      = 4,
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] GLOBAL_ADDR = 10'h0F0,
    localparam int               BANK_W      = $clog2(NPORTS),
    localparam int               OFS_W       = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              bulk_en,
    output logic              glob_hit,
    output logic [BANK_W-1:0] bank_sel,
    output logic [OFS_W-1:0]  port_ofs,
    output logic [NPORTS-1:0] port_wr,
    output logic [NPORTS-1:0] port_rd,
    output logic              rd_blocked
);

    // Split the address into the global hit, the bank index and the offset.
    always_comb begin
        glob_hit = (host_addr == GLOBAL_ADDR);
        bank_sel = host_addr[ADDR_W-1 -: BANK_W];
        port_ofs = host_addr[OFS_W-1:0];
    end

    // One write strobe and one read strobe per bank.
    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_strobe
        logic sel_here;
        assign sel_here    = (bank_sel == BANK_W'(gi));
        assign port_wr[gi] = host_wr & ~glob_hit & (bulk_en | sel_here);
        assign port_rd[gi] = host_rd & ~glob_hit & ~bulk_en & sel_here;
    end

    // A bank read under broadcast is refused and reported.
    assign rd_blocked = host_rd & ~glob_hit & bulk_en;

    // R3: outside broadcast, at most one bank is written.
    a_r3_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !bulk_en |-> $onehot0(port_wr));

    // R4: under broadcast, writes go to no bank or to every bank.
    a_r4_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_en |-> ($countones(port_wr) == 0 || $countones(port_wr) == NPORTS));

    // R5: a read never selects more than one bank.
    a_r5_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_rd));

endmodule

// File: rtl/qgc_ctrl_reg.sv
// Global control register and counter-latch edge detector.
// Stores the writable fields and forces reserved bits to 0. Produces a
// one-cycle pulse when a write takes the latch field from 0 to 1.
// Assumes one register write per host_wr cycle.
module qgc_ctrl_reg
    import qgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              latch_pulse
);

    ctrl_t wr_val;

    // Drop the reserved bits from the incoming write.
    always_comb wr_val = ctrl_t'(wdata & CTRL_WMASK);

    // Register update on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_val;
    end

    // Pulse in the cycle after a write that raises the latch field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_pulse <= 1'b0;
        else
            latch_pulse <= wr_en & wr_val.latch & ~ctrl_q.latch;
    end

    // R8: the pulse never lasts longer than one cycle.
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> !latch_pulse);

    // R7: a pulse is only seen while the latch field holds 1.
    a_r7_pulse_with_field: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |-> ctrl_q.latch);

endmodule

// File: rtl/qgc_out_gate.sv
// Output gating for the global control fields.
// Registers the inhibitable active-low interrupt, selects the per-port
// status source, and gates the latch pulse with each port's enable.
// Assumes port_irq already carries only unmasked pending conditions.
module qgc_out_gate #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit,
    input  logic              stat_sel,
    input  logic              latch_pulse,
    input  logic [NPORTS-1:0] latch_en,
    input  logic [NPORTS-1:0] port_irq,
    input  logic [NPORTS-1:0] port_rlof,
    input  logic [NPORTS-1:0] port_ltc,
    output logic              irq_n,
    output logic [NPORTS-1:0] port_stat,
    output logic [NPORTS-1:0] port_latch
);

    // Registered active-low interrupt, forced high while inhibited.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= inhibit | ~(|port_irq);
    end

    // Per-port status source and latch delivery.
    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        assign port_stat[gi]  = stat_sel ? port_ltc[gi] : port_rlof[gi];
        assign port_latch[gi] = latch_pulse & latch_en[gi];
    end

    // R9: inhibit holds the interrupt inactive.
    a_r9_inhibit_high: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> irq_n);

    // R9: a pending interrupt without inhibit pulls the line low.
    a_r9_pending_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && (|port_irq)) |=> !irq_n);

endmodule

// File: rtl/qport_global_ctrl.sv
// Top of the quad-port global control block.
// Connects the host bus to four port register banks through the address
// decode, holds the global control register, and drives the latch,
// interrupt, status and combining-mode outputs.
// Assumes reads are combinational: host_rdata is valid while host_rd is high.
module qport_global_ctrl
    import qgc_pkg::*;
#(
    parameter int                NPORTS      = 4,
    parameter int                ADDR_W      = 10,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] GLOBAL_ADDR = 10'h0F0,
    localparam int               BANK_W      = $clog2(NPORTS),
    localparam int               OFS_W       = ADDR_W - BANK_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    input  logic                     host_wr,
    input  logic                     host_rd,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     bulk_rd_err,
    output logic [OFS_W-1:0]         port_addr,
    output logic [DATA_W-1:0]        port_wdata,
    output logic [NPORTS-1:0]        port_wr,
    output logic [NPORTS-1:0]        port_rd,
    input  logic [NPORTS*DATA_W-1:0] port_rdata,
    input  logic [NPORTS-1:0]        port_latch_en,
    output logic [NPORTS-1:0]        port_latch,
    input  logic [NPORTS-1:0]        port_irq,
    output logic                     irq_n,
    input  logic [NPORTS-1:0]        port_rlof,
    input  logic [NPORTS-1:0]        port_ltc,
    output logic [NPORTS-1:0]        port_stat,
    output logic                     wire_or_mode
);

    logic              glob_hit;
    logic [BANK_W-1:0] bank_sel;
    logic              rd_blocked;
    logic              latch_pulse;
    ctrl_t             ctrl_q;

    qgc_addr_decode #(
        .NPORTS      (NPORTS),
        .ADDR_W      (ADDR_W),
        .GLOBAL_ADDR (GLOBAL_ADDR)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .bulk_en    (ctrl_q.bulk),
        .glob_hit   (glob_hit),
        .bank_sel   (bank_sel),
        .port_ofs   (port_addr),
        .port_wr    (port_wr),
        .port_rd    (port_rd),
        .rd_blocked (rd_blocked)
    );

    qgc_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (host_wr & glob_hit),
        .wdata       (host_wdata[CTRL_W-1:0]),
        .ctrl_q      (ctrl_q),
        .latch_pulse (latch_pulse)
    );

    qgc_out_gate #(
        .NPORTS (NPORTS)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .inhibit     (ctrl_q.inhibit),
        .stat_sel    (ctrl_q.stat_sel),
        .latch_pulse (latch_pulse),
        .latch_en    (port_latch_en),
        .port_irq    (port_irq),
        .port_rlof   (port_rlof),
        .port_ltc    (port_ltc),
        .irq_n       (irq_n),
        .port_stat   (port_stat),
        .port_latch  (port_latch)
    );

    // Write data passes straight through to every bank.
    assign port_wdata   = host_wdata;
    assign wire_or_mode = ctrl_q.wor_mode;

    // Read return: global register, refused bank read, or selected bank.
    always_comb begin
        host_rdata = '0;
        if (glob_hit)
            host_rdata[CTRL_W-1:0] = ctrl_q;
        else if (!ctrl_q.bulk)
            host_rdata = port_rdata[bank_sel*DATA_W +: DATA_W];
    end

    // One-cycle flag after a bank read refused under broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bulk_rd_err <= 1'b0;
        else
            bulk_rd_err <= rd_blocked;
    end

    // R2: reserved bits of the global register always read 0.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && glob_hit) |->
            (host_rdata[7:6] == 2'b00 && host_rdata[3] == 1'b0));

    // R6: a refused bank read is flagged in the next cycle.
    a_r6_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !glob_hit && ctrl_q.bulk) |=> bulk_rd_err);

    // R6: a refused read strobes no bank.
    a_r6_no_bank_read: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.bulk |-> (port_rd == '0));

endmodule

// File: tb/qport_global_ctrl_tb_top.sv
// Self-checking bench: four bank models driven by the design's strobes,
// sweeps over addresses, register values, enables and status inputs.
module qport_global_ctrl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NP         = 4;
    localparam logic [9:0]  GADDR      = 10'h0F0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  host_addr;
    logic [7:0]  host_wdata;
    logic        host_wr;
    logic        host_rd;
    logic [7:0]  host_rdata;
    logic        bulk_rd_err;
    logic [7:0]  port_addr;
    logic [7:0]  port_wdata;
    logic [3:0]  port_wr;
    logic [3:0]  port_rd;
    logic [31:0] port_rdata;
    logic [3:0]  port_latch_en;
    logic [3:0]  port_latch;
    logic [3:0]  port_irq;
    logic        irq_n;
    logic [3:0]  port_rlof;
    logic [3:0]  port_ltc;
    logic [3:0]  port_stat;
    logic        wire_or_mode;

    int n_checks = 0;
    int n_errors = 0;

    // Bank storage driven by the design, and the bench's expected copy.
    logic [7:0] bank_mem [NP][256];
    logic [7:0] exp_bank [NP][256];
    logic       m_bulk;

    always #(CLK_PERIOD/2) clk = ~clk;

    qport_global_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .bulk_rd_err(bulk_rd_err),
        .port_addr(port_addr), .port_wdata(port_wdata),
        .port_wr(port_wr), .port_rd(port_rd), .port_rdata(port_rdata),
        .port_latch_en(port_latch_en), .port_latch(port_latch),
        .port_irq(port_irq), .irq_n(irq_n),
        .port_rlof(port_rlof), .port_ltc(port_ltc), .port_stat(port_stat),
        .wire_or_mode(wire_or_mode)
    );

    // Bank models: write on strobe, read combinationally.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NP; p++)
            if (port_wr[p]) bank_mem[p][port_addr] <= port_wdata;
    end

    always_comb begin
        for (int p = 0; p < NP; p++)
            port_rdata[p*8 +: 8] = bank_mem[p][port_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    // Host write; checks the strobes in the write cycle and updates the model.
    task automatic do_write(input logic [9:0] a, input logic [7:0] d);
        logic [3:0] exp_wr;
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        #1;
        if (a == GADDR)  exp_wr = 4'h0;
        else if (m_bulk) exp_wr = 4'hF;
        else             exp_wr = 4'b0001 << a[9:8];
        check(port_wr == exp_wr, m_bulk ? "R4" : "R3", "port_wr", 32'(port_wr), 32'(exp_wr));
        if (a != GADDR)
            check(port_addr == a[7:0], "R3", "port_addr", 32'(port_addr), 32'(a[7:0]));
        if (a == GADDR) m_bulk = d[2];
        else
            for (int p = 0; p < NP; p++)
                if (exp_wr[p]) exp_bank[p][a[7:0]] = d;
        @(negedge clk);
        host_wr = 1'b0;
        #1;
    endtask

    // Host read; returns data, strobes and the error flag of the next cycle.
    task automatic do_read(input logic [9:0] a, output logic [7:0] d,
                           output logic [3:0] rs, output logic err);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1;
        d  = host_rdata;
        rs = port_rd;
        @(negedge clk);
        host_rd = 1'b0;
        #1;
        err = bulk_rd_err;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        report();
    end

    initial begin
        logic [7:0] rd;
        logic [3:0] rs;
        logic       err;
        logic [9:0] a;

        for (int p = 0; p < NP; p++)
            for (int o = 0; o < 256; o++) begin
                bank_mem[p][o] = 8'h00;
                exp_bank[p][o] = 8'h00;
            end
        m_bulk = 1'b0;
        rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
        port_latch_en = 4'h0; port_irq = 4'hF; port_rlof = 4'h0; port_ltc = 4'h0;

        // R1: reset state, interrupt held inactive even with pending inputs.
        repeat (3) @(negedge clk);
        #1;
        check(irq_n == 1'b1, "R1", "irq_n in reset", 32'(irq_n), 1);
        port_irq = 4'h0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(port_latch == 4'h0, "R1", "port_latch", 32'(port_latch), 0);
        check(bulk_rd_err == 1'b0, "R1", "bulk_rd_err", 32'(bulk_rd_err), 0);
        check(wire_or_mode == 1'b0, "R1", "wire_or_mode", 32'(wire_or_mode), 0);
        do_read(GADDR, rd, rs, err);
        check(rd == 8'h00, "R1", "global reset value", 32'(rd), 0);
        check(irq_n == 1'b1, "R1", "irq_n after reset", 32'(irq_n), 1);

        // R2 / R11: every register value, reserved bits masked.
        for (int v = 0; v < 256; v++) begin
            do_write(GADDR, 8'(v));
            check(wire_or_mode == v[4], "R11", "wire_or_mode", 32'(wire_or_mode), 32'(v[4]));
            do_read(GADDR, rd, rs, err);
            check(rd == (8'(v) & 8'h37), "R2", "global readback", 32'(rd), 32'(v & 8'h37));
            check(err == 1'b0, "R6", "no error on global read", 32'(err), 0);
        end
        do_write(GADDR, 8'h00);

        // R3: single-bank writes over every bank and offset.
        for (int p = 0; p < NP; p++)
            for (int o = 0; o < 256; o++) begin
                a = 10'(p*256 + o);
                if (a != GADDR) do_write(a, 8'(p*37 + o*5 + 1));
            end

        // R5: read every location back with broadcast clear.
        for (int p = 0; p < NP; p++)
            for (int o = 0; o < 256; o++) begin
                a = 10'(p*256 + o);
                if (a != GADDR) begin
                    do_read(a, rd, rs, err);
                    check(rs == (4'b0001 << p), "R5", "port_rd", 32'(rs), 32'(4'b0001 << p));
                    check(rd == exp_bank[p][o], "R5", "bank data", 32'(rd), 32'(exp_bank[p][o]));
                    check(err == 1'b0, "R5", "no error", 32'(err), 0);
                end
            end

        // R4: broadcast writes, including a register write inside broadcast.
        do_write(GADDR, 8'h04);
        for (int k = 0; k < 40; k++) begin
            a = 10'((k % 4)*256 + (k*7 + 3) % 256);
            if (a != GADDR) do_write(a, 8'(k*13 + 8'h5A));
        end
        do_write(GADDR, 8'h04);

        // R6: reads under broadcast.
        do_read(GADDR, rd, rs, err);
        check(rd == 8'h04, "R6", "global read in broadcast", 32'(rd), 4);
        check(err == 1'b0, "R6", "no error on global", 32'(err), 0);
        for (int p = 0; p < NP; p++) begin
            do_read(10'(p*256 + 10), rd, rs, err);
            check(rs == 4'h0, "R6", "no port_rd", 32'(rs), 0);
            check(rd == 8'h00, "R6", "zero data", 32'(rd), 0);
            check(err == 1'b1, "R6", "error flag", 32'(err), 1);
            @(negedge clk);
            #1;
            check(bulk_rd_err == 1'b0, "R6", "flag one cycle", 32'(bulk_rd_err), 0);
        end
        do_write(GADDR, 8'h00);

        // R3 / R4: full comparison of the bank models.
        for (int p = 0; p < NP; p++)
            for (int o = 0; o < 256; o++)
                check(bank_mem[p][o] == exp_bank[p][o], "R4", "bank contents",
                      32'(bank_mem[p][o]), 32'(exp_bank[p][o]));

        // R7 / R8: latch pulse over every enable pattern.
        for (int en = 0; en < 16; en++) begin
            port_latch_en = 4'(en);
            do_write(GADDR, 8'h00);
            check(port_latch == 4'h0, "R8", "no pulse on clear", 32'(port_latch), 0);
            do_write(GADDR, 8'h02);
            check(port_latch == 4'(en), "R7", "pulse on rise", 32'(port_latch), 32'(en));
            @(negedge clk);
            #1;
            check(port_latch == 4'h0, "R8", "pulse one cycle", 32'(port_latch), 0);
            do_write(GADDR, 8'h02);
            check(port_latch == 4'h0, "R8", "rewrite while set", 32'(port_latch), 0);
            do_write(GADDR, 8'h13);
            check(port_latch == 4'h0, "R8", "other bits change", 32'(port_latch), 0);
            do_write(GADDR, 8'h00);
            do_write(GADDR, 8'h02);
            check(port_latch == 4'(en), "R8", "re-armed pulse", 32'(port_latch), 32'(en));
        end
        port_latch_en = 4'h0;

        // R9: interrupt gate, both inhibit settings.
        do_write(GADDR, 8'h00);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            port_irq = 4'(i);
            @(negedge clk);
            #1;
            check(irq_n == (i == 0), "R9", "irq_n enabled", 32'(irq_n), 32'(i == 0));
        end
        do_write(GADDR, 8'h01);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            port_irq = 4'(i);
            @(negedge clk);
            #1;
            check(irq_n == 1'b1, "R9", "irq_n inhibited", 32'(irq_n), 1);
        end
        port_irq = 4'h0;

        // R10: status source over every input pattern.
        for (int s = 0; s < 2; s++) begin
            do_write(GADDR, 8'(s << 5));
            for (int r = 0; r < 16; r++)
                for (int l = 0; l < 16; l++) begin
                    @(negedge clk);
                    port_rlof = 4'(r);
                    port_ltc  = 4'(l);
                    #1;
                    check(port_stat == (s == 1 ? 4'(l) : 4'(r)), "R10", "port_stat",
                          32'(port_stat), 32'(s == 1 ? l : r));
                end
        end

        report();
    end

endmodule